// File: doc/BRIEF.md
# Load-Use Stall Controller

This block lives in the decode stage of a five-stage in-order pipeline. Each cycle it compares the instruction held in decode against the instruction one stage ahead in execute. If the execute-stage instruction reads data memory and its destination register is one of the two source registers of the decode-stage instruction, it requests a single stall. A stall holds the program counter and the fetch/decode register. It also puts an all-zero control word, a bubble, into the decode/execute register. The next cycle the load has moved on to memory, the condition clears, and forwarding outside this block supplies the loaded value.

To make the stall observable as a whole, the block also contains the registers it acts on. These are the program counter, the fetch/decode instruction register, a small control decoder, the decode/execute control and target-register fields, and the memory/write-back control fields of the execute/memory register. Instruction words use a fixed layout: opcode in bits [31:26], first source register in bits [25:21], second source register in bits [20:16]. The fetched word enters as an input that matches the current program counter.

Top module: `lu_stall_ctrl`

## Requirements
- R1: A stall is raised in the cycle where the decode/execute memory-read bit is 1 and the decode/execute target register equals bits [25:21] of the fetch/decode instruction.
- R2: A stall is likewise raised when that target register equals bits [20:16] of the fetch/decode instruction.
- R3: Each detected hazard costs exactly one stall cycle. In the cycle after a stall, stall is low, and the dependent instruction's control word reaches decode/execute one cycle later than it would have without the stall.
- R4: While stalled, the PC write enable is low and the program counter keeps its value. Otherwise it advances by 4.
- R5: While stalled, the fetch/decode write enable is low and the fetch/decode instruction does not change.
- R6: On the edge that ends a stall cycle, the whole decode/execute control word becomes zero. Otherwise it takes the decoded word. The decoded word has bits [8] register write, [7] memory-to-register, [6] branch, [5] memory read, [4] memory write, [3] register-destination select, [2:1] ALU op, [0] ALU source. The codes are: opcode 0x00 gives 0x10C, 0x23 gives 0x1A1, 0x2B gives 0x011, 0x04 gives 0x042, and any other opcode gives 0x000.
- R7: The instruction in decode/execute moves into execute/memory whether or not a stall is in progress. The execute/memory control output equals bits [8:4] of the previous decode/execute word.
- R8: While reset is low, stall is low, and the program counter, fetch/decode instruction and all pipeline control fields are cleared to zero.
- R9: A load whose target is register 0 never causes a stall.
- R10: When the decode/execute memory-read bit is 0, no stall is raised, even if the register fields match.
- R11: Without a stall, fetch/decode captures the fetched word on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_instr | input | 32 | Instruction word at the current program counter |
| pc_out | output | 32 | Program counter |
| ifid_instr_out | output | 32 | Fetch/decode instruction register |
| idex_ctrl_out | output | 9 | Decode/execute control word |
| idex_rt_out | output | 5 | Decode/execute target register field |
| exmem_ctrl_out | output | 5 | Execute/memory control fields (write-back and memory) |
| stall_out | output | 1 | Load-use stall request |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode write enable |
| bubble_sel | output | 1 | Selects the zero control word into decode/execute |

## Verification
Two things overlap in the stall cycle: the hazard check freezing the front of the pipe, and the load ahead of it draining into execute/memory. Each table vector pairs a first and second instruction that place a load in execute next to a dependent or independent decode instruction. On the edge after detection, the bench checks both effects together: the program counter and fetch/decode are held, the bubble appears, and the execute/memory fields carry the load's bits. A directed case also raises reset while a stall is active, and another runs two back-to-back dependent loads so that two stalls fall two cycles apart.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int OP_W   = 6;
  localparam int OP_LSB = 26;
  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;

  localparam logic [OP_W-1:0] OP_ALU   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  typedef struct packed {
    logic reg_wr;
    logic mem_to_reg;
  } wb_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_ctl_t;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
  } ex_ctl_t;

  typedef struct packed {
    wb_ctl_t  wb;
    mem_ctl_t mem;
    ex_ctl_t  ex;
  } ctrl_t;

  typedef struct packed {
    wb_ctl_t  wb;
    mem_ctl_t mem;
  } late_ctl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int LATE_W = $bits(late_ctl_t);

  function automatic logic [OP_W-1:0] f_op(input logic [XLEN-1:0] w);
    return w[OP_LSB +: OP_W];
  endfunction

  function automatic logic [REG_AW-1:0] f_rs(input logic [XLEN-1:0] w);
    return w[RS_LSB +: REG_AW];
  endfunction

  function automatic logic [REG_AW-1:0] f_rt(input logic [XLEN-1:0] w);
    return w[RT_LSB +: REG_AW];
  endfunction

  // true when a nonzero producer register feeds the given consumer field
  function automatic logic f_dep(input logic [REG_AW-1:0] prod,
                                 input logic [REG_AW-1:0] cons);
    return (prod != '0) && (prod == cons);
  endfunction
endpackage

// File: rtl/lu_ctrl_decode.sv
module lu_ctrl_decode
  import lu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctrl
);
  logic [OP_W-1:0] op;
  assign op = f_op(instr);

  always_comb begin
    ctrl = '0;
    case (op)
      OP_ALU: begin
        ctrl.ex.reg_dst  = 1'b1;
        ctrl.ex.alu_op   = 2'b10;
        ctrl.wb.reg_wr   = 1'b1;
      end
      OP_LOAD: begin
        ctrl.ex.alu_src    = 1'b1;
        ctrl.mem.mem_rd    = 1'b1;
        ctrl.wb.reg_wr     = 1'b1;
        ctrl.wb.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl.ex.alu_src = 1'b1;
        ctrl.mem.mem_wr = 1'b1;
      end
      OP_BEQ: begin
        ctrl.ex.alu_op   = 2'b01;
        ctrl.mem.branch  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/lu_hazard_detect.sv
module lu_hazard_detect
  import lu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  output logic              stall,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              bubble_sel
);
  logic rs_hit, rt_hit, any_hit;

  assign rs_hit     = f_dep(ex_rt, id_rs);
  assign rt_hit     = f_dep(ex_rt, id_rt);
  assign any_hit    = ex_mem_rd && (rs_hit || rt_hit);
  assign stall      = rst_n && any_hit;
  assign pc_wr_en   = !stall;
  assign ifid_wr_en = !stall;
  assign bubble_sel = stall;

  // R9
  zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_rt != '0));

  // R10
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_mem_rd |-> !stall);

  // R8
  always_comb begin
    if (rst_n === 1'b0) begin
      reset_quiet_chk: assert (!stall);
    end
  end
endmodule

// File: rtl/lu_pipe_regs.sv
module lu_pipe_regs
  import lu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              PC_STEP  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_wr_en,
  input  logic              ifid_wr_en,
  input  logic              bubble_sel,
  input  logic [XLEN-1:0]   fetch_instr,
  input  ctrl_t             dec_ctrl,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   ifid_q,
  output ctrl_t             idex_q,
  output logic [REG_AW-1:0] idex_rt_q,
  output late_ctl_t         exmem_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  ctrl_t idex_d;
  assign idex_d = bubble_sel ? ctrl_t'('0) : dec_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= RESET_PC;
      ifid_q    <= '0;
      idex_q    <= '0;
      idex_rt_q <= '0;
      exmem_q   <= '0;
    end else begin
      if (pc_wr_en)   pc_q   <= pc_q + STEP;
      if (ifid_wr_en) ifid_q <= fetch_instr;
      idex_q    <= idex_d;
      idex_rt_q <= f_rt(ifid_q);
      exmem_q   <= {idex_q.wb, idex_q.mem};
    end
  end

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_wr_en |=> (pc_q == $past(pc_q)));

  // R5
  ifid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_wr_en |=> $stable(ifid_q));

  // R6
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_sel |=> (idex_q == '0));

  // R7
  load_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_q.mem.mem_rd |=> (exmem_q.mem.mem_rd && exmem_q.wb.mem_to_reg));
endmodule

// File: rtl/lu_stall_ctrl.sv
module lu_stall_ctrl
  import lu_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              PC_STEP  = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   fetch_instr,
  output logic [XLEN-1:0]   pc_out,
  output logic [XLEN-1:0]   ifid_instr_out,
  output logic [CTRL_W-1:0] idex_ctrl_out,
  output logic [REG_AW-1:0] idex_rt_out,
  output logic [LATE_W-1:0] exmem_ctrl_out,
  output logic              stall_out,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              bubble_sel
);
  ctrl_t             dec_ctrl;
  ctrl_t             idex_q;
  late_ctl_t         exmem_q;
  logic [XLEN-1:0]   pc_q, ifid_q;
  logic [REG_AW-1:0] idex_rt_q;
  logic              stall;

  lu_ctrl_decode u_dec (
    .instr (ifid_q),
    .ctrl  (dec_ctrl)
  );

  lu_hazard_detect u_haz (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_mem_rd  (idex_q.mem.mem_rd),
    .ex_rt      (idex_rt_q),
    .id_rs      (f_rs(ifid_q)),
    .id_rt      (f_rt(ifid_q)),
    .stall      (stall),
    .pc_wr_en   (pc_wr_en),
    .ifid_wr_en (ifid_wr_en),
    .bubble_sel (bubble_sel)
  );

  lu_pipe_regs #(.RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_wr_en    (pc_wr_en),
    .ifid_wr_en  (ifid_wr_en),
    .bubble_sel  (bubble_sel),
    .fetch_instr (fetch_instr),
    .dec_ctrl    (dec_ctrl),
    .pc_q        (pc_q),
    .ifid_q      (ifid_q),
    .idex_q      (idex_q),
    .idex_rt_q   (idex_rt_q),
    .exmem_q     (exmem_q)
  );

  assign pc_out         = pc_q;
  assign ifid_instr_out = ifid_q;
  assign idex_ctrl_out  = idex_q;
  assign idex_rt_out    = idex_rt_q;
  assign exmem_ctrl_out = exmem_q;
  assign stall_out      = stall;

  // R3
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
endmodule

// File: tb/lu_stall_ctrl_tb.sv
`timescale 1ns/1ps
module lu_stall_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_instr;
  logic [31:0] pc_out, ifid_instr_out;
  logic [8:0]  idex_ctrl_out;
  logic [4:0]  idex_rt_out;
  logic [4:0]  exmem_ctrl_out;
  logic        stall_out, pc_wr_en, ifid_wr_en, bubble_sel;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] prog [8];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] ins(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt);
    return {op, rs, rt, 16'h0};
  endfunction

  localparam logic [31:0] NOP = {6'h3F, 26'h0};

  always_comb fetch_instr = (pc_out < 32'd32) ? prog[pc_out[4:2]] : NOP;

  lu_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
    .pc_out(pc_out), .ifid_instr_out(ifid_instr_out),
    .idex_ctrl_out(idex_ctrl_out), .idex_rt_out(idex_rt_out),
    .exmem_ctrl_out(exmem_ctrl_out), .stall_out(stall_out),
    .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .bubble_sel(bubble_sel)
  );

  // {first[31:0], ctrl_first[8:0], second[31:0], ctrl_second[8:0], stall}
  localparam int NV = 9;
  localparam logic [82:0] VEC [NV] = '{
    {ins(6'h23,5'd2,5'd1),  9'h1A1, ins(6'h00,5'd1,5'd5),   9'h10C, 1'b1}, // R1
    {ins(6'h23,5'd2,5'd1),  9'h1A1, ins(6'h00,5'd5,5'd1),   9'h10C, 1'b1}, // R2
    {ins(6'h23,5'd2,5'd1),  9'h1A1, ins(6'h00,5'd4,5'd5),   9'h10C, 1'b0}, // R11
    {ins(6'h23,5'd2,5'd0),  9'h1A1, ins(6'h00,5'd0,5'd0),   9'h10C, 1'b0}, // R9
    {ins(6'h00,5'd2,5'd1),  9'h10C, ins(6'h00,5'd1,5'd1),   9'h10C, 1'b0}, // R10
    {ins(6'h23,5'd2,5'd3),  9'h1A1, ins(6'h2B,5'd3,5'd7),   9'h011, 1'b1}, // R1
    {ins(6'h23,5'd2,5'd3),  9'h1A1, ins(6'h2B,5'd2,5'd3),   9'h011, 1'b1}, // R2
    {ins(6'h2B,5'd2,5'd3),  9'h011, ins(6'h04,5'd3,5'd3),   9'h042, 1'b0}, // R10
    {ins(6'h23,5'd2,5'd31), 9'h1A1, ins(6'h04,5'd31,5'd31), 9'h042, 1'b1}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic restart(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 8; k++) prog[k] = NOP;
    prog[0] = a; prog[1] = b; prog[2] = c;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) prog[k] = NOP;
    #1;
    // R8: state during reset
    check("R8 stall", {31'b0, stall_out}, 32'd0);
    @(negedge clk);
    check("R8 pc", pc_out, 32'd0);
    check("R8 ifid", ifid_instr_out, 32'd0);
    check("R8 idex", {23'b0, idex_ctrl_out}, 32'd0);
    check("R8 exmem", {27'b0, exmem_ctrl_out}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] i0, i1;
      logic [8:0]  c0, c1;
      logic        st;
      {i0, c0, i1, c1, st} = VEC[v];
      restart(i0, i1, NOP);
      step(); // edge1
      check("R11 ifid first", ifid_instr_out, i0);
      step(); // edge2: first in ID/EX, second in IF/ID
      check("R6 idex first", {23'b0, idex_ctrl_out}, {23'b0, c0});
      check("R1 R2 stall", {31'b0, stall_out}, {31'b0, st});
      check("R4 pc_wr_en", {31'b0, pc_wr_en}, {31'b0, !st});
      check("R5 ifid_wr_en", {31'b0, ifid_wr_en}, {31'b0, !st});
      step(); // edge3
      check("R7 exmem", {27'b0, exmem_ctrl_out}, {27'b0, c0[8:4]});
      if (st) begin
        check("R4 pc held", pc_out, 32'd8);
        check("R5 ifid held", ifid_instr_out, i1);
        check("R6 bubble", {23'b0, idex_ctrl_out}, 32'd0);
        check("R3 stall drops", {31'b0, stall_out}, 32'd0);
        step(); // edge4
        check("R3 second ctrl late", {23'b0, idex_ctrl_out}, {23'b0, c1});
        check("R4 pc advance", pc_out, 32'd12);
      end else begin
        check("R4 pc advance", pc_out, 32'd12);
        check("R11 ifid next", ifid_instr_out, NOP);
        check("R6 second ctrl", {23'b0, idex_ctrl_out}, {23'b0, c1});
      end
    end

    // R3: two dependent loads back to back give two separate single stalls
    restart(ins(6'h23,5'd2,5'd1), ins(6'h23,5'd1,5'd4), ins(6'h00,5'd4,5'd4));
    step(); step();
    check("R3 first stall", {31'b0, stall_out}, 32'd1);
    step();
    check("R3 gap", {31'b0, stall_out}, 32'd0);
    step();
    check("R3 second stall", {31'b0, stall_out}, 32'd1);
    check("R4 pc before hold", pc_out, 32'd12);
    step();
    check("R4 pc held again", pc_out, 32'd12);
    check("R7 second load drained", {27'b0, exmem_ctrl_out}, {27'b0, 5'b11010});

    // R8: reset while a stall is up
    restart(ins(6'h23,5'd2,5'd1), ins(6'h00,5'd1,5'd5), NOP);
    step(); step();
    check("R1 stall before reset", {31'b0, stall_out}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 stall under reset", {31'b0, stall_out}, 32'd0);
    check("R8 pc cleared", pc_out, 32'd0);
    check("R8 idex cleared", {23'b0, idex_ctrl_out}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule